// File: doc/BRIEF.md
# Banked data memory decoder

This block sits between the operand path of a small 8-bit controller core and its data space. The data space is split into two banks of 128 bytes. The core gives a 7-bit offset from the instruction word, a bank-select bit and the current contents of its 8-bit indirect pointer. The block decides which location the access reaches. Low offsets in each bank go to an external special-register port. Higher offsets go to general-purpose RAM held inside the block. A top slice of bank 1 is a window onto the same cells as the top slice of bank 0. Offset zero is not storage: it redirects the access through the pointer. Any other location reads as zero and ignores writes.

Reads are registered. The core raises `rd_en` in one cycle, and the byte appears on `rd_data` after the next clock edge. Writes to RAM take effect on that same edge. Writes to special registers are passed out on the register port in the cycle they are requested. Registers that the core keeps in both banks (program-counter low byte, status, pointer, program-counter latch, interrupt control) are presented on the port under their bank-0 address. The peripheral side then decodes one address for each of them.

Top module: `dmem_bank_decoder`

## Requirements
- R1: A direct access with a non-zero offset reaches the address {bank_sel, dir_ofs}. Bank-0 offsets 20h–7Fh are read/write RAM cells.
- R2: Offsets 01h–1Fh in either bank select the register port. `reg_sel` is high in the request cycle, `reg_wr` is high when `wr_en` is also high, `reg_wdata` carries `wr_data`, and a read returns `reg_rdata` sampled in the request cycle. No RAM cell changes.
- R3: In bank 1, offsets 02h, 03h, 04h, 0Ah and 0Bh appear on `reg_addr` with bit 7 clear, as their bank-0 twin. Every other register address keeps its bank bit in `reg_addr[7]`.
- R4: Bank-1 addresses F0h–FFh read and write the same cells as bank-0 addresses 70h–7Fh.
- R5: With `B1_GPR_EN` = 1 (the default), bank-1 addresses A0h–BFh are 32 RAM cells separate from all bank-0 cells. With 0, they are unimplemented.
- R6: Unimplemented addresses (bank 1 C0h–EFh, and A0h–BFh in the small configuration) read as 00h, and a write to them changes no RAM cell.
- R7: A direct offset of 00h uses `ind_ptr` as the full address: bit 7 is the bank and bits 6:0 the offset. `bank_sel` is ignored.
- R8: An indirect access whose pointer is 00h or 80h reads 00h, writes nothing and does not select the register port.
- R9: `rd_data` is 00h after reset. It loads on the clock edge that ends a cycle with `rd_en` high, and holds its value otherwise. A read and a write to the same cell in one cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dir_ofs | input | 7 | Offset field from the instruction |
| bank_sel | input | 1 | Bank select for direct access |
| ind_ptr | input | 8 | Indirect pointer value (bit 7 bank, bits 6:0 offset) |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| reg_sel | output | 1 | Register port select |
| reg_wr | output | 1 | Register port write strobe |
| reg_addr | output | 8 | Register address, shared registers folded to bank 0 |
| reg_wdata | output | 8 | Register port write data |
| reg_rdata | input | 8 | Register port read data |

## Verification
A wrong bank or window fold in the resolver sends a write into the wrong cell. This shows up only when a later read hits either cell, so random traffic confined to 256 addresses revisits each cell within a few hundred operations. A wrong register-port decision is visible at once, in the request cycle, on `reg_sel`, `reg_wr` or `reg_addr`. A broken read register shows up one edge after the read as a wrong or non-zero byte on `rd_data`, or as a change of `rd_data` in a cycle without `rd_en`.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  parameter int unsigned DMEM_OFS_W = 7;
  parameter int unsigned DMEM_DW    = 8;

  // Where a resolved access lands.
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,  // pointer redirected to offset zero
    RGN_SFR  = 2'd1,  // external register port
    RGN_GPR  = 2'd2,  // internal RAM cell
    RGN_HOLE = 2'd3   // unimplemented, reads zero
  } dmem_region_e;

  // Core registers that exist once but are visible from both banks.
  function automatic logic is_dual_sfr(input logic [DMEM_OFS_W-1:0] ofs);
    logic hit;
    case (ofs)
      7'h02, 7'h03, 7'h04, 7'h0A, 7'h0B: hit = 1'b1;
      default:                           hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/dmem_addr_resolve.sv
module dmem_addr_resolve
  import dmem_pkg::*;
#(
  parameter int unsigned OFS_W       = DMEM_OFS_W,
  parameter int unsigned SFR_SPAN    = 32,
  parameter int unsigned COMMON_SPAN = 16,
  parameter int unsigned B1_GPR_SPAN = 32,
  parameter bit          B1_GPR_EN   = 1'b1,
  parameter int unsigned IDX_W       = 7
) (
  input  logic [OFS_W-1:0] dir_ofs,
  input  logic             bank_sel,
  input  logic [OFS_W:0]   ind_ptr,
  output dmem_region_e     region,
  output logic [OFS_W:0]   reg_addr,
  output logic [IDX_W-1:0] gpr_idx
);

  localparam int unsigned BANK_SIZE = 1 << OFS_W;
  localparam int unsigned B0_SPAN   = BANK_SIZE - SFR_SPAN;
  localparam logic [OFS_W-1:0] SFR_LIM    = OFS_W'(SFR_SPAN);
  localparam logic [OFS_W-1:0] COMMON_LIM = OFS_W'(BANK_SIZE - COMMON_SPAN);
  localparam logic [OFS_W-1:0] B1_LIM     = OFS_W'(SFR_SPAN + B1_GPR_SPAN);
  localparam logic [IDX_W-1:0] B1_BASE    = IDX_W'(B0_SPAN);

  logic [OFS_W:0]   eff;
  logic [OFS_W-1:0] ofs;
  logic             bnk;
  logic             b1_hit;

  // Offset zero redirects through the pointer; the bank bit then comes from it.
  assign eff = (dir_ofs == '0) ? ind_ptr : {bank_sel, dir_ofs};
  assign ofs = eff[OFS_W-1:0];
  assign bnk = eff[OFS_W];

  generate
    if (B1_GPR_EN) begin : g_b1_gpr
      assign b1_hit = bnk && (ofs >= SFR_LIM) && (ofs < B1_LIM);
    end else begin : g_no_b1_gpr
      assign b1_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    region   = RGN_HOLE;
    reg_addr = eff;
    gpr_idx  = '0;
    if (ofs == '0) begin
      region = RGN_NONE;
    end else if (ofs < SFR_LIM) begin
      region = RGN_SFR;
      if (bnk && is_dual_sfr(DMEM_OFS_W'(ofs))) reg_addr[OFS_W] = 1'b0;
    end else if (!bnk || (ofs >= COMMON_LIM)) begin
      // bank 0 RAM, and the bank-1 window folded onto its top slice
      region  = RGN_GPR;
      gpr_idx = IDX_W'(ofs - SFR_LIM);
    end else if (b1_hit) begin
      region  = RGN_GPR;
      gpr_idx = B1_BASE + IDX_W'(ofs - SFR_LIM);
    end
  end

endmodule

// File: rtl/dmem_gpr_array.sv
module dmem_gpr_array #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 128,
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);

  localparam logic [IDX_W:0] DEPTH_LIM = (IDX_W+1)'(DEPTH);

  // Storage has no reset: contents are undefined until written.
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[idx] <= wdata;
  end

  assign rdata = cells[idx];

  // R5: a write never addresses past the implemented cells
  p_write_in_range_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    we |-> ({1'b0, idx} < DEPTH_LIM));

endmodule

// File: rtl/dmem_bank_decoder.sv
module dmem_bank_decoder
  import dmem_pkg::*;
#(
  parameter int unsigned DW          = DMEM_DW,
  parameter int unsigned OFS_W       = DMEM_OFS_W,
  parameter int unsigned SFR_SPAN    = 32,
  parameter int unsigned COMMON_SPAN = 16,
  parameter int unsigned B1_GPR_SPAN = 32,
  parameter bit          B1_GPR_EN   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFS_W-1:0] dir_ofs,
  input  logic             bank_sel,
  input  logic [OFS_W:0]   ind_ptr,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  output logic             reg_sel,
  output logic             reg_wr,
  output logic [OFS_W:0]   reg_addr,
  output logic [DW-1:0]    reg_wdata,
  input  logic [DW-1:0]    reg_rdata
);

  localparam int unsigned BANK_SIZE = 1 << OFS_W;
  localparam int unsigned B0_SPAN   = BANK_SIZE - SFR_SPAN;
  localparam int unsigned DEPTH     = B0_SPAN + (B1_GPR_EN ? B1_GPR_SPAN : 0);
  localparam int unsigned IDX_W     = $clog2(DEPTH);
  localparam logic [OFS_W-1:0] SFR_LIM = OFS_W'(SFR_SPAN);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  dmem_region_e     region;
  logic [OFS_W:0]   res_addr;
  logic [IDX_W-1:0] gpr_idx;
  logic [DW-1:0]    gpr_q;
  logic             gpr_we;
  logic             access;

  dmem_addr_resolve #(
    .OFS_W      (OFS_W),
    .SFR_SPAN   (SFR_SPAN),
    .COMMON_SPAN(COMMON_SPAN),
    .B1_GPR_SPAN(B1_GPR_SPAN),
    .B1_GPR_EN  (B1_GPR_EN),
    .IDX_W      (IDX_W)
  ) u_resolve (
    .dir_ofs (dir_ofs),
    .bank_sel(bank_sel),
    .ind_ptr (ind_ptr),
    .region  (region),
    .reg_addr(res_addr),
    .gpr_idx (gpr_idx)
  );

  assign access = rd_en || wr_en;
  assign gpr_we = wr_en && (region == RGN_GPR);

  dmem_gpr_array #(
    .DW   (DW),
    .DEPTH(DEPTH),
    .IDX_W(IDX_W)
  ) u_gpr (
    .clk    (clk),
    .rst_q_n(rst_q_n),
    .we     (gpr_we),
    .idx    (gpr_idx),
    .wdata  (wr_data),
    .rdata  (gpr_q)
  );

  // Register port
  assign reg_sel   = access && (region == RGN_SFR);
  assign reg_wr    = wr_en && (region == RGN_SFR);
  assign reg_addr  = res_addr;
  assign reg_wdata = wr_data;

  // Read data register: next-state logic, then the flop.
  logic [DW-1:0] rd_q;
  logic [DW-1:0] rd_d;
  logic          rd_ce;

  assign rd_ce = rd_en;

  always_comb begin
    case (region)
      RGN_SFR: rd_d = reg_rdata;
      RGN_GPR: rd_d = gpr_q;
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)   rd_q <= '0;
    else if (rd_ce) rd_q <= rd_d;
  end

  assign rd_data = rd_q;

  // R6: unimplemented locations read back as zero
  p_hole_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_en && (region == RGN_HOLE)) |=> (rd_data == '0));

  // R8: pointer aimed at offset zero yields zero and touches nothing
  p_null_ptr_read_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_en && (dir_ofs == '0) && (ind_ptr[OFS_W-1:0] == '0)) |=> (rd_data == '0));
  p_null_ptr_quiet_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((dir_ofs == '0) && (ind_ptr[OFS_W-1:0] == '0)) |-> (!reg_sel && !gpr_we));

  // R2: register port only ever sees offsets 01h..top of the register span
  p_reg_port_range_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    reg_sel |-> ((reg_addr[OFS_W-1:0] != '0) && (reg_addr[OFS_W-1:0] < SFR_LIM)));

  // R2: register read data passes through the read register unchanged
  p_reg_read_data_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_en && reg_sel) |=> (rd_data == $past(reg_rdata)));

  // R3: a shared register never leaves with its bank-1 address
  p_shared_folded_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    reg_sel |-> !(reg_addr[OFS_W] && is_dual_sfr(DMEM_OFS_W'(reg_addr[OFS_W-1:0]))));

  // R9: read data holds when no read is requested
  p_read_hold_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !rd_en |=> $stable(rd_data));

endmodule

// File: tb/dmem_bank_decoder_bench.sv
`timescale 1ns/1ps
module dmem_bank_decoder_bench;

  localparam int KIND_NONE = 0;
  localparam int KIND_SFR  = 1;
  localparam int KIND_RAM  = 2;
  localparam int KIND_HOLE = 3;

  logic       clk;
  logic       rst_n;
  logic [6:0] dir_ofs;
  logic       bank_sel;
  logic [7:0] ind_ptr;
  logic       rd_en;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       reg_sel;
  logic       reg_wr;
  logic [7:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;

  int unsigned n_vec;
  int unsigned n_bad;

  logic [7:0] model [256];
  bit         known [256];
  logic [7:0] last_rd;

  // Peripheral stand-in: value derived from the address it is asked for.
  assign reg_rdata = reg_sel ? (reg_addr ^ 8'hC3) : 8'h00;

  dmem_bank_decoder u_dmem_bank_decoder (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir_ofs  (dir_ofs),
    .bank_sel (bank_sel),
    .ind_ptr  (ind_ptr),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .reg_sel  (reg_sel),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit shared_reg(input logic [6:0] o);
    return (o == 7'h02) || (o == 7'h03) || (o == 7'h04) || (o == 7'h0A) || (o == 7'h0B);
  endfunction

  // Reference: kind in bits 9:8, canonical address in 7:0.
  function automatic logic [9:0] ref_resolve(input logic [6:0] d, input logic b, input logic [7:0] p);
    logic [7:0] e;
    e = (d == 7'h00) ? p : {b, d};
    if (e[6:0] == 7'h00)      return {2'(KIND_NONE), e};
    if (e[6:0] < 7'h20)       return {2'(KIND_SFR), (e[7] && shared_reg(e[6:0])) ? {1'b0, e[6:0]} : e};
    if (!e[7])                return {2'(KIND_RAM), e};
    if (e[6:0] >= 7'h70)      return {2'(KIND_RAM), 1'b0, e[6:0]};
    if (e[6:0] < 7'h40)       return {2'(KIND_RAM), e};
    return {2'(KIND_HOLE), e};
  endfunction

  function automatic string ram_tag(input logic [6:0] d, input logic [7:0] e);
    if (d == 7'h00) return "R7";
    if (e[7])       return "R5";
    return "R1";
  endfunction

  // One operation: drive at a falling edge, check the port in that cycle,
  // check rd_data at the next falling edge.
  task automatic do_op(input logic [6:0] d, input logic b, input logic [7:0] p,
                       input logic r, input logic w, input logic [7:0] wd);
    logic [9:0] res;
    int         kind;
    logic [7:0] a;
    logic [7:0] raw;
    logic [7:0] exp_rd;
    bit         exp_known;
    string      rtag;
    res  = ref_resolve(d, b, p);
    kind = int'(res[9:8]);
    a    = res[7:0];
    raw  = (d == 7'h00) ? p : {b, d};
    dir_ofs = d; bank_sel = b; ind_ptr = p; rd_en = r; wr_en = w; wr_data = wd;
    #1;
    check(reg_sel == ((kind == KIND_SFR) && (r || w)), (kind == KIND_NONE) ? "R8" : "R2",
          {7'b0, reg_sel}, {7'b0, ((kind == KIND_SFR) && (r || w))});
    check(reg_wr == ((kind == KIND_SFR) && w), "R2", {7'b0, reg_wr}, {7'b0, ((kind == KIND_SFR) && w)});
    if ((kind == KIND_SFR) && (r || w)) begin
      check(reg_addr == a, "R3", reg_addr, a);
      if (w) check(reg_wdata == wd, "R2", reg_wdata, wd);
    end
    exp_known = 1'b1;
    exp_rd    = 8'h00;
    rtag      = "R9";
    case (kind)
      KIND_NONE: rtag = "R8";
      KIND_HOLE: rtag = "R6";
      KIND_SFR:  begin rtag = "R2"; exp_rd = a ^ 8'hC3; end
      default: begin
        rtag = ((raw[7]) && (raw[6:0] >= 7'h70)) ? "R4" : ram_tag(d, raw);
        exp_rd = model[a];
        exp_known = known[a];
      end
    endcase
    @(posedge clk);
    if (w && (kind == KIND_RAM)) begin
      model[a] = wd;
      known[a] = 1'b1;
    end
    @(negedge clk);
    if (r) begin
      if (exp_known) check(rd_data == exp_rd, rtag, rd_data, exp_rd);
      last_rd = rd_data;
    end else begin
      check(rd_data == last_rd, "R9", rd_data, last_rd);
    end
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec = 0; n_bad = 0;
    for (int i = 0; i < 256; i++) begin model[i] = 8'h00; known[i] = 1'b0; end
    rst_n = 1'b0; dir_ofs = 7'h00; bank_sel = 1'b0; ind_ptr = 8'h00;
    rd_en = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    check(rd_data == 8'h00, "R9", rd_data, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(rd_data == 8'h00, "R9", rd_data, 8'h00);
    last_rd = 8'h00;

    // Fill every RAM cell directly (R1, R5).
    for (int o = 8'h20; o < 8'h80; o++)
      do_op(7'(o), 1'b0, 8'h00, 1'b0, 1'b1, 8'(o * 7 + 3));
    for (int o = 8'h20; o < 8'h40; o++)
      do_op(7'(o), 1'b1, 8'h00, 1'b0, 1'b1, 8'(o * 11 + 5));

    // R1: bank-0 readback
    do_op(7'h45, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00);
    // R5: bank-1 cell distinct from bank-0 cell at same offset
    do_op(7'h25, 1'b1, 8'h00, 1'b1, 1'b0, 8'h00);
    do_op(7'h25, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00);
    // R4: write through window, read from bank 0 and back
    do_op(7'h72, 1'b1, 8'h00, 1'b0, 1'b1, 8'hAA);
    do_op(7'h72, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00);
    do_op(7'h7F, 1'b0, 8'h00, 1'b0, 1'b1, 8'h5D);
    do_op(7'h7F, 1'b1, 8'h00, 1'b1, 1'b0, 8'h00);
    // R3 and R2: shared and unshared registers in bank 1
    do_op(7'h03, 1'b1, 8'h00, 1'b1, 1'b0, 8'h00);
    do_op(7'h0B, 1'b1, 8'h00, 1'b0, 1'b1, 8'h81);
    do_op(7'h05, 1'b1, 8'h00, 1'b1, 1'b0, 8'h00);
    do_op(7'h1F, 1'b0, 8'h00, 1'b1, 1'b1, 8'h3C);
    // R6: hole write changes nothing, reads zero
    do_op(7'h50, 1'b1, 8'h00, 1'b0, 1'b1, 8'hEE);
    do_op(7'h50, 1'b1, 8'h00, 1'b1, 1'b0, 8'h00);
    do_op(7'h50, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00);
    do_op(7'h70, 1'b1, 8'h00, 1'b1, 1'b0, 8'h00);
    // R7: pointer picks bank, bank_sel ignored
    do_op(7'h00, 1'b0, 8'hA5, 1'b1, 1'b0, 8'h00);
    do_op(7'h00, 1'b1, 8'h30, 1'b0, 1'b1, 8'h77);
    do_op(7'h30, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00);
    do_op(7'h00, 1'b0, 8'h83, 1'b1, 1'b0, 8'h00);
    // R8: pointer at offset zero
    do_op(7'h00, 1'b1, 8'h80, 1'b1, 1'b0, 8'h00);
    do_op(7'h00, 1'b0, 8'h00, 1'b1, 1'b1, 8'h99);
    // R9: read and write the same cell in one cycle, then idle hold
    do_op(7'h40, 1'b0, 8'h00, 1'b1, 1'b1, 8'h12);
    do_op(7'h40, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00);
    do_op(7'h41, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);

    // Random traffic with a fixed seed.
    void'($urandom(32'd4021));
    for (int i = 0; i < 4000; i++) begin
      logic [6:0] d;
      logic [31:0] rv;
      rv = $urandom();
      d  = (rv[2:0] == 3'd0) ? 7'h00 : rv[9:3];
      do_op(d, rv[10], rv[18:11], rv[19], rv[20], rv[28:21]);
    end

    rd_en = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule